// File: doc/BRIEF.md
# Burst Transmit Sequencer with RF-Enable Lead

This block runs one reverse-channel transmit burst. A burst is made of a host-chosen number of fixed-size coded blocks. The host first arms the sequencer with a transmit-enable level. It then pulses a start command, which loads the block count, and keeps a byte buffer fed. The sequencer waits until a whole block sits in the buffer and the end of a channel-idle flag has been reported. It then raises an RF-enable output. A fixed number of bit ticks later it begins shifting the buffered bytes out serially, one bit per tick. After the last bit of the last block it lowers RF-enable and returns the data output to its idle level.

The buffer has no empty indication. If the host stops supplying bytes during a burst, the shifter keeps sending whatever word the buffer presents, and that data is undefined. A status output mirrors RF-enable. A sticky transmit-RF interrupt flag is set on both edges of RF-enable, and a mask input gates it onto the interrupt line. The transmit-enable level is never cleared by the block.

The controller has four states. `ST_IDLE` moves to `ST_ARMED` on an accepted start. `ST_ARMED` moves back to `ST_IDLE` when transmit-enable drops, and moves to `ST_LEAD` on launch. `ST_LEAD` moves to `ST_SHIFT` when the lead count expires. `ST_SHIFT` moves back to `ST_IDLE` after the final bit.

Top module: `burst_tx_seq`

## Requirements
- R1: After reset, rf_en, rf_status, tx_active, txd, irq_flag, irq and buf_full are all 0.
- R2: A start pulse is accepted only when tx_enable is 1 and block_count is nonzero. Otherwise the sequencer stays idle, and a later idle_end causes no launch.
- R3: rf_en does not rise while the buffer holds fewer than BLOCK_BYTES bytes.
- R4: When armed with a full block buffered, rf_en rises on the clock edge that samples idle_end. If the block completes later, it rises on the edge after the block is complete, provided fewer than START_WIN-LEAD_TICKS bit ticks have passed since idle_end. Once that window has passed, launch waits for the next idle_end.
- R5: Exactly LEAD_TICKS bit ticks pass while rf_en is 1 and tx_active is still 0. The edge that takes the last of them raises tx_active.
- R6: Serial data leaves least-significant bit first, bytes in the order they were written, and each bit is held for one bit-tick interval.
- R7: A burst carries block_count × BLOCK_BYTES × 8 bits. rf_en and tx_active fall on the same edge. While tx_active is 0, txd is 0, which is the idle level.
- R8: rf_status equals rf_en in every cycle.
- R9: irq_flag is set one cycle after each rise and each fall of rf_en. It stays set until irq_clear is pulsed. A set event in the same cycle as irq_clear wins.
- R10: irq is irq_flag gated by irq_mask.
- R11: When the buffer holds FIFO_DEPTH bytes, buf_full is 1 and further writes are dropped.
- R12: Dropping tx_enable while armed returns the sequencer to idle, so a following idle_end causes no launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmit-enable arm level |
| start | input | 1 | Start command pulse |
| block_count | input | CNT_W | Blocks in the burst, sampled at start |
| idle_end | input | 1 | Pulse at the last bit of a detected idle flag |
| wr_valid | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write byte |
| buf_full | output | 1 | Buffer holds FIFO_DEPTH bytes |
| rf_en | output | 1 | RF-enable |
| rf_status | output | 1 | Status mirror of RF-enable |
| tx_active | output | 1 | Serial data valid; 0 means idle level |
| txd | output | 1 | Serial data |
| irq_mask | input | 1 | Interrupt mask (1 enables) |
| irq_clear | input | 1 | Write-1 clear of the interrupt flag |
| irq_flag | output | 1 | Sticky transmit-RF interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with BLOCK_BYTES=2, FIFO_DEPTH=4, LEAD_TICKS=2 and START_WIN=8, and drives a bit tick every fourth clock. With these values a two-block burst fills the buffer exactly, so the full flag, the dropped write and multi-block counting can all be reached with a handful of bytes. The launch window is only six ticks long, so a test can wait it out in a few dozen cycles. Every lead and bit interval spans several clocks, which lets the bench attribute each serial bit to one tick.

// File: rtl/btx_pkg.sv
package btx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LEAD  = 2'd2,
        ST_SHIFT = 2'd3
    } btx_state_e;
endpackage

// File: rtl/btx_buf.sv
module btx_buf #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full
);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_ok, rd_ok;

    assign full  = (level == FULL_LVL);
    assign wr_ok = push && !full;
    assign rd_ok = pop && (level != '0);
    // An empty buffer still presents a stale word: the shifter sends it as undefined data.
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    p_drop_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(level));
endmodule

// File: rtl/btx_fsm.sv
module btx_fsm
    import btx_pkg::*;
#(
    parameter int BLOCK_BYTES = 4,
    parameter int LEAD_TICKS  = 2,
    parameter int START_WIN   = 8,
    parameter int CNT_W       = 4,
    parameter int LVL_W       = 4,
    localparam int LC_W       = $clog2(LEAD_TICKS + 1),
    localparam int WC_W       = $clog2(START_WIN + 1),
    localparam int BY_W       = $clog2(BLOCK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_enable,
    input  logic             start,
    input  logic [CNT_W-1:0] block_count,
    input  logic             idle_end,
    input  logic [LVL_W-1:0] level,
    input  logic [7:0]       rd_data,
    output logic             pop,
    output logic             rf_en,
    output logic             tx_active,
    output logic             txd_bit
);
    localparam logic [LVL_W-1:0] BLK_L     = LVL_W'(BLOCK_BYTES);
    localparam logic [LC_W-1:0]  LEAD_LAST = LC_W'(LEAD_TICKS - 1);
    localparam logic [WC_W-1:0]  WIN_LAST  = WC_W'(START_WIN - LEAD_TICKS - 1);
    localparam logic [BY_W-1:0]  BYTE_LAST = BY_W'(BLOCK_BYTES - 1);

    btx_state_e       state, state_d;
    logic [CNT_W-1:0] blk_left;
    logic [BY_W-1:0]  byte_idx;
    logic [2:0]       bit_idx;
    logic [LC_W-1:0]  lead_cnt;
    logic [WC_W-1:0]  win_cnt;
    logic             win_open;
    logic [7:0]       shreg;
    logic             ready, go, lead_done, byte_done, burst_done;

    assign ready      = (level >= BLK_L);
    assign go         = tx_enable && ready && (idle_end || win_open);
    assign lead_done  = bit_tick && (lead_cnt == LEAD_LAST);
    assign byte_done  = bit_tick && (bit_idx == 3'd7);
    assign burst_done = byte_done && (byte_idx == BYTE_LAST) && (blk_left == CNT_W'(1));
    assign txd_bit    = shreg[0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Next state and buffer pop
    always_comb begin
        state_d = state;
        pop     = 1'b0;
        unique case (state)
            ST_IDLE:  if (start && tx_enable && (block_count != '0)) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!tx_enable) state_d = ST_IDLE;
                else if (go)    state_d = ST_LEAD;
            end
            ST_LEAD: if (lead_done) begin
                state_d = ST_SHIFT;
                pop     = 1'b1;
            end
            ST_SHIFT: begin
                if (burst_done)     state_d = ST_IDLE;
                else if (byte_done) pop     = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_en     <= 1'b0;
            tx_active <= 1'b0;
            shreg     <= '0;
            blk_left  <= '0;
            byte_idx  <= '0;
            bit_idx   <= '0;
            lead_cnt  <= '0;
            win_cnt   <= '0;
            win_open  <= 1'b0;
        end else begin
            if (state != ST_ARMED) begin
                win_open <= 1'b0;
            end else if (idle_end) begin
                win_open <= 1'b1;
                win_cnt  <= '0;
            end else if (win_open && bit_tick) begin
                if (win_cnt == WIN_LAST) win_open <= 1'b0;
                else                     win_cnt  <= win_cnt + 1'b1;
            end

            unique case (state)
                ST_IDLE: if (start) blk_left <= block_count;
                ST_ARMED: if (tx_enable && go) begin
                    rf_en    <= 1'b1;
                    lead_cnt <= '0;
                end
                ST_LEAD: if (lead_done) begin
                    tx_active <= 1'b1;
                    shreg     <= rd_data;
                    bit_idx   <= '0;
                    byte_idx  <= '0;
                end else if (bit_tick) begin
                    lead_cnt <= lead_cnt + 1'b1;
                end
                ST_SHIFT: if (burst_done) begin
                    rf_en     <= 1'b0;
                    tx_active <= 1'b0;
                end else if (byte_done) begin
                    shreg   <= rd_data;
                    bit_idx <= '0;
                    if (byte_idx == BYTE_LAST) begin
                        byte_idx <= '0;
                        blk_left <= blk_left - 1'b1;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end else if (bit_tick) begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_launch_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_en) |-> ($past(level) >= BLK_L));
    p_lead_before_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(rf_en));
    p_data_under_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> rf_en);
    p_end_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rf_en) |-> $fell(tx_active));
endmodule

// File: rtl/btx_irq.sv
module btx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rf_i,
    input  logic mask,
    input  logic clr,
    output logic flag_o,
    output logic irq_o
);
    logic rf_prev;
    logic set_ev;

    assign set_ev = (rf_i != rf_prev);
    assign irq_o  = flag_o && mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_prev <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            rf_prev <= rf_i;
            if (set_ev)   flag_o <= 1'b1;
            else if (clr) flag_o <= 1'b0;
        end
    end

    p_set_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_i != $past(rf_i)) |=> flag_o);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);
endmodule

// File: rtl/burst_tx_seq.sv
module burst_tx_seq #(
    parameter int BLOCK_BYTES = 4,
    parameter int FIFO_DEPTH  = 8,
    parameter int LEAD_TICKS  = 2,
    parameter int START_WIN   = 8,
    parameter int CNT_W       = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_enable,
    input  logic             start,
    input  logic [CNT_W-1:0] block_count,
    input  logic             idle_end,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             buf_full,
    output logic             rf_en,
    output logic             rf_status,
    output logic             tx_active,
    output logic             txd,
    input  logic             irq_mask,
    input  logic             irq_clear,
    output logic             irq_flag,
    output logic             irq
);
    logic [LVL_W-1:0] level;
    logic [7:0]       rd_data;
    logic             pop;
    logic             txd_bit;

    btx_buf #(.DEPTH(FIFO_DEPTH), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .din(wr_data),
        .pop(pop), .dout(rd_data), .level(level), .full(buf_full)
    );

    btx_fsm #(
        .BLOCK_BYTES(BLOCK_BYTES), .LEAD_TICKS(LEAD_TICKS),
        .START_WIN(START_WIN), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(tx_enable),
        .start(start), .block_count(block_count), .idle_end(idle_end),
        .level(level), .rd_data(rd_data), .pop(pop), .rf_en(rf_en),
        .tx_active(tx_active), .txd_bit(txd_bit)
    );

    btx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .rf_i(rf_en), .mask(irq_mask),
        .clr(irq_clear), .flag_o(irq_flag), .irq_o(irq)
    );

    assign rf_status = rf_en;
    assign txd       = tx_active && txd_bit;

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !txd);
endmodule

// File: tb/tb_burst_tx_seq.sv
module tb_burst_tx_seq;
    localparam int BB = 2, DEPTH = 4, LEAD = 2, WIN = 8, CW = 4, TDIV = 4;

    logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, tx_enable = 1'b0, start = 1'b0;
    logic [CW-1:0] block_count = '0;
    logic idle_end = 1'b0, wr_valid = 1'b0, irq_mask = 1'b0, irq_clear = 1'b0;
    logic [7:0] wr_data = '0;
    logic buf_full, rf_en, rf_status, tx_active, txd, irq_flag, irq;

    burst_tx_seq #(.BLOCK_BYTES(BB), .FIFO_DEPTH(DEPTH), .LEAD_TICKS(LEAD),
                   .START_WIN(WIN), .CNT_W(CW)) dut (.*);

    always #2 clk = ~clk;

    int tests = 0, fails = 0;
    int tick_div = 0, lead_seen = 0, cap_n = 0, mirror_err = 0, exp_n = 0;
    logic cap [256];
    logic [7:0] exp_b [16];

    // Tick generator and bit monitor: sample outputs held during the coming tick edge.
    always @(negedge clk) begin
        if (tick_div == TDIV - 1) begin
            tick_div = 0;
            bit_tick = 1'b1;
            if (rf_en && !tx_active) lead_seen++;
            if (tx_active && cap_n < 256) begin cap[cap_n] = txd; cap_n++; end
        end else begin
            tick_div++;
            bit_tick = 1'b0;
        end
        if (rf_status !== rf_en) mirror_err++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b, input bit expect_kept);
        wr_valid = 1'b1; wr_data = b;
        step(1);
        wr_valid = 1'b0;
        if (expect_kept) begin exp_b[exp_n] = b; exp_n++; end
    endtask

    task automatic arm(input int cnt);
        block_count = CW'(cnt); start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic pulse_idle();
        idle_end = 1'b1;
        step(1);
        idle_end = 1'b0;
    endtask

    task automatic finish_burst();
        int guard = 0;
        while (!rf_en && guard < 200) begin step(1); guard++; end
        step(2);
        irq_clear = 1'b1; step(1); irq_clear = 1'b0;
        chk("R9 flag cleared by irq_clear", irq_flag, 1'b0);
        guard = 0;
        while (rf_en && guard < 2000) begin step(1); guard++; end
        chk("R7 tx_active falls with rf_en", tx_active, 1'b0);
        chk("R7 txd idle level", txd, 1'b0);
        step(1);
        chk("R9 flag set on rf_en fall", irq_flag, 1'b1);
        chk("R5 lead ticks", lead_seen, LEAD);
        chk("R7 burst bit count", cap_n, exp_n * 8);
        for (int i = 0; i < exp_n; i++)
            for (int j = 0; j < 8; j++)
                if (i * 8 + j < cap_n)
                    chk($sformatf("R6 byte %0d bit %0d", i, j), cap[i*8+j], exp_b[i][j]);
        irq_clear = 1'b1; step(1); irq_clear = 1'b0;
        lead_seen = 0; cap_n = 0; exp_n = 0;
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 rf_en in reset", rf_en, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 outputs after reset",
            {buf_full, rf_en, rf_status, tx_active, txd, irq_flag, irq}, 7'b0);
    endtask

    task automatic t_basic();
        tx_enable = 1'b1;
        arm(1);
        push(8'hA5, 1); push(8'h3C, 1);
        pulse_idle();
        chk("R4 launch on idle_end edge", rf_en, 1'b1);
        finish_burst();
        chk("R8 status mirrors rf_en", mirror_err, 0);
    endtask

    task automatic t_wait_block();
        arm(1);
        push(8'h81, 1);
        pulse_idle();
        chk("R3 no launch with partial block", rf_en, 1'b0);
        step(3);
        chk("R3 still held", rf_en, 1'b0);
        push(8'h7E, 1);
        step(1);
        chk("R4 launch inside window after block completes", rf_en, 1'b1);
        finish_burst();
    endtask

    task automatic t_window();
        arm(1);
        pulse_idle();
        step(TDIV * 8);
        push(8'h12, 1); push(8'hF0, 1);
        step(4);
        chk("R4 no launch after window", rf_en, 1'b0);
        pulse_idle();
        chk("R4 launch on next idle_end", rf_en, 1'b1);
        finish_burst();
    endtask

    task automatic t_start_gate();
        tx_enable = 1'b0;
        arm(1);
        tx_enable = 1'b1;
        push(8'h5A, 1); push(8'hC3, 1);
        pulse_idle();
        chk("R2 start ignored without tx_enable", rf_en, 1'b0);
        arm(0);
        pulse_idle();
        chk("R2 start ignored with zero count", rf_en, 1'b0);
        arm(1);
        pulse_idle();
        chk("R2 valid start launches", rf_en, 1'b1);
        finish_burst();
    endtask

    task automatic t_abort();
        arm(1);
        push(8'h0F, 1); push(8'h99, 1);
        tx_enable = 1'b0; step(1); tx_enable = 1'b1;
        pulse_idle();
        chk("R12 disarmed by tx_enable drop", rf_en, 1'b0);
        arm(1);
        pulse_idle();
        chk("R12 rearm launches", rf_en, 1'b1);
        finish_burst();
    endtask

    task automatic t_multi_full();
        arm(2);
        push(8'h01, 1); push(8'h80, 1); push(8'hB6, 1); push(8'h4D, 1);
        chk("R11 buf_full at depth", buf_full, 1'b1);
        push(8'hEE, 0);
        chk("R11 still full after dropped write", buf_full, 1'b1);
        pulse_idle();
        finish_burst();
        chk("R11 buffer drained", buf_full, 1'b0);
    endtask

    task automatic t_irq();
        arm(1);
        push(8'h66, 1); push(8'h29, 1);
        pulse_idle();
        step(2);
        chk("R10 masked irq low", {irq_flag, irq}, 2'b10);
        irq_mask = 1'b1;
        step(1);
        chk("R10 unmasked irq high", irq, 1'b1);
        finish_burst();
        irq_mask = 1'b0;
        // Set on rf_en rise coincides with a clear: set must win (R9).
        irq_clear = 1'b1; step(1); irq_clear = 1'b0;
        arm(1);
        push(8'hD2, 1); push(8'h17, 1);
        pulse_idle();
        irq_clear = 1'b1; step(1); irq_clear = 1'b0;
        chk("R9 set wins over clear", irq_flag, 1'b1);
        finish_burst();
    endtask

    initial begin
        #600000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_wait_block();
        t_window();
        t_start_gate();
        t_abort();
        t_multi_full();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule